// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits next to a 32-bit RISC pipeline and owns the registers that describe exception state. These are the status word, the cause word, the saved return address, the error return address and the exception base. It also holds the load-linked flag and the current instruction-set mode bit. When the pipeline raises an exception, the block updates these registers and issues a redirect to the handler vector. When the pipeline executes an exception-return instruction, it picks the return address and restores the instruction-set mode. Every update and the redirect land together on the clock edge that follows the request.

The exception level is tracked by a four-state machine. The states are LV_BASE (neither level bit set), LV_EXL (exception level), LV_ERL (error level) and LV_BOTH (both bits set). The transitions are:
- ENTER: any state goes to LV_EXL.
- RETURN_ERR: LV_ERL goes to LV_BASE, and LV_BOTH goes to LV_EXL.
- RETURN_EXC: LV_EXL goes to LV_BASE, and LV_BASE stays in LV_BASE.
- LOAD: any state goes to the state encoded by a status write.

The pipeline reaches the status, cause, return address, error return address and base registers through a one-cycle write port. This is how it sets the boot-vector bit, the vectored-interrupt bit and the base.

Inputs are accepted in a fixed priority. An entry (an exception request or a coprocessor-unusable strobe) comes first, then a return, then a register write. A request of lower priority arriving in the same cycle is dropped.

Top module: `xcpt_ctrl`

## Requirements
- R1: Reset forces status to 0x00400000 (only the boot-vector bit 22 set), cause to 0, base to 0x80000000, mode bit to 0, the load-linked flag to 0, and the redirect output to idle with address 0.
- R2: On entry while status bit 1 (exception level) is 0, the return address register takes the faulting PC ORed with the mode bit, and cause bit 31 takes the delay-slot flag.
- R3: On entry while status bit 1 is already 1, the return address register and cause bit 31 keep their values.
- R4: On entry, cause bits [6:2] take the code and every other cause bit is kept. The codes are 0 interrupt, 2 and 3 refill load and store, 8 syscall, 9 breakpoint, 11 coprocessor unusable and 13 trap.
- R5: Every entry sets status bit 1 and clears status bit 2 (error level). The level machine moves to LV_EXL.
- R6: The generic vector is 0xBFC00380 when status bit 22 is 1, and base + 0x180 otherwise.
- R7: When status bit 1 was 0, codes 2 and 3 use vector offset 0x000 from the base. When it was 1, they use the generic offset.
- R8: When status bit 1 was 0, code 0 with cause bit 23 set uses offset 0x200 from the base.
- R9: A return with status bit 2 set clears only bit 2 and goes to the error return address.
- R10: A return with status bit 2 clear clears bit 1 and goes to the return address. Every accepted return clears the load-linked flag, which is otherwise set by the set strobe. The mode bit takes bit 0 of the target, and the redirect address has bit 0 cleared.
- R11: The coprocessor-unusable strobe raises an entry with code 11, whatever the code input holds, and sets cause bit 28.
- R12: Every entry clears the mode bit.
- R13: The redirect valid output is high for exactly the one cycle after an accepted entry or return. Entry outranks return, and return outranks a write, in the same cycle.
- R14: Register write selects are 0 status, 1 cause, 2 return address, 3 error return address and 4 base. A cause write changes only bits 28, 23 and 15:8. A base write changes only bits 31:12. Selects 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request |
| exc_code | input | 5 | Exception code |
| exc_bd | input | 1 | Faulting instruction is in a delay slot |
| exc_pc | input | 32 | Faulting PC |
| isa_in | input | 1 | Current instruction-set mode bit |
| cu_req | input | 1 | Coprocessor-unusable strobe |
| eret_req | input | 1 | Exception-return strobe |
| ll_set | input | 1 | Load-linked flag set strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 32 | Register write data |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Redirect target |
| isa_mode | output | 1 | Instruction-set mode after redirect |
| ll_flag | output | 1 | Load-linked flag |
| status_q | output | 32 | Status register |
| cause_q | output | 32 | Cause register |
| epc_q | output | 32 | Return address register |
| errorepc_q | output | 32 | Error return address register |
| ebase_q | output | 32 | Exception base register |

## Verification
The bench concentrates on several corner cases, each of which shows up as a specific wrong value:
- A nested entry. A design that does not freeze the return address there would overwrite it with the nested PC and lose the first handler's way back.
- Refill and vectored-interrupt codes with the level bit already set. A design that ignores the old level would send a nested miss to offset 0 instead of 0x180.
- A return with both level bits set. A design that checks the wrong bit first would clear the exception level and jump to the ordinary return address.
- Simultaneous entry, return and write. A design with the wrong priority would corrupt the status word or leave the load-linked flag clear.
- A coprocessor-unusable strobe carrying a stray code. A design that passes the code input through would record the wrong cause.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;

    typedef enum logic [1:0] {
        LV_BASE = 2'b00,
        LV_EXL  = 2'b01,
        LV_ERL  = 2'b10,
        LV_BOTH = 2'b11
    } lvl_e;

    localparam int ST_EXL_BIT = 1;
    localparam int ST_ERL_BIT = 2;
    localparam int ST_BEV_BIT = 22;
    localparam int CA_BD_BIT  = 31;
    localparam int CA_CE_BIT  = 28;
    localparam int CA_IV_BIT  = 23;
    localparam int CA_EC_LO   = 2;
    localparam int CA_EC_HI   = 6;

    localparam logic [4:0] EC_INT  = 5'd0;
    localparam logic [4:0] EC_TLBL = 5'd2;
    localparam logic [4:0] EC_TLBS = 5'd3;
    localparam logic [4:0] EC_CPU  = 5'd11;

    localparam logic [2:0] SEL_STATUS = 3'd0;
    localparam logic [2:0] SEL_CAUSE  = 3'd1;
    localparam logic [2:0] SEL_EPC    = 3'd2;
    localparam logic [2:0] SEL_ERREPC = 3'd3;
    localparam logic [2:0] SEL_EBASE  = 3'd4;

    localparam logic [31:0] CAUSE_WMASK = 32'h1080_FF00;

endpackage

// File: rtl/xcpt_level_fsm.sv
module xcpt_level_fsm
    import xcpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ent,
    input  logic ret,
    input  logic wr,
    input  logic wr_exl,
    input  logic wr_erl,
    output logic exl,
    output logic erl
);

    lvl_e st_q;
    lvl_e st_n;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LV_BASE;
        else        st_q <= st_n;
    end

    always_comb begin
        st_n = st_q;
        if (ent) begin
            st_n = LV_EXL;                      // ENTER
        end else if (ret) begin
            unique case (st_q)
                LV_BASE: st_n = LV_BASE;        // RETURN_EXC
                LV_EXL:  st_n = LV_BASE;        // RETURN_EXC
                LV_ERL:  st_n = LV_BASE;        // RETURN_ERR
                LV_BOTH: st_n = LV_EXL;         // RETURN_ERR
                default: st_n = LV_BASE;
            endcase
        end else if (wr) begin
            st_n = lvl_e'({wr_erl, wr_exl});    // LOAD
        end
    end

    always_comb begin
        unique case (st_q)
            LV_BASE: begin exl = 1'b0; erl = 1'b0; end
            LV_EXL:  begin exl = 1'b1; erl = 1'b0; end
            LV_ERL:  begin exl = 1'b0; erl = 1'b1; end
            LV_BOTH: begin exl = 1'b1; erl = 1'b1; end
            default: begin exl = 1'b0; erl = 1'b0; end
        endcase
    end

endmodule

// File: rtl/xcpt_vector.sv
module xcpt_vector
    import xcpt_pkg::*;
#(
    parameter int          AW         = 32,
    parameter logic [31:0] BOOT_BASE  = 32'hBFC0_0200,
    parameter logic [31:0] OFF_GEN    = 32'h180,
    parameter logic [31:0] OFF_REFILL = 32'h000,
    parameter logic [31:0] OFF_INT    = 32'h200
) (
    input  logic          bev,
    input  logic [AW-1:0] ebase,
    input  logic          old_exl,
    input  logic [4:0]    code,
    input  logic          iv,
    output logic [AW-1:0] vec
);

    logic [AW-1:0] base;
    logic [AW-1:0] off;

    always_comb begin
        base = bev ? AW'(BOOT_BASE) : ebase;
        off  = AW'(OFF_GEN);
        if (!old_exl) begin
            if (code == EC_TLBL || code == EC_TLBS) off = AW'(OFF_REFILL);
            else if (code == EC_INT && iv)          off = AW'(OFF_INT);
        end
        vec = base + off;
    end

endmodule

// File: rtl/xcpt_regfile.sv
module xcpt_regfile
    import xcpt_pkg::*;
#(
    parameter int          AW          = 32,
    parameter int          EBASE_LSB   = 12,
    parameter logic [31:0] RESET_EBASE = 32'h8000_0000,
    parameter logic [31:0] RESET_STAT  = 32'h0040_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_ent,
    input  logic          take_ret,
    input  logic          wr_ok,
    input  logic [2:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic [4:0]    ent_code,
    input  logic          ent_bd,
    input  logic [AW-1:0] ent_pc,
    input  logic          ent_isa,
    input  logic          ent_cu,
    input  logic          old_exl,
    input  logic          use_err,
    input  logic          exl,
    input  logic          erl,
    input  logic [AW-1:0] vec,
    input  logic          ll_set,
    output logic [AW-1:0] status,
    output logic [AW-1:0] cause,
    output logic [AW-1:0] epc,
    output logic [AW-1:0] errorepc,
    output logic [AW-1:0] ebase,
    output logic          isa,
    output logic          ll,
    output logic          rv,
    output logic [AW-1:0] rpc
);

    localparam int EBW = AW - EBASE_LSB;
    localparam logic [AW-1:0] LVL_MASK = AW'((1 << ST_EXL_BIT) | (1 << ST_ERL_BIT));

    logic [AW-1:0]  stat_rest_q;
    logic [AW-1:0]  cause_q, cause_n;
    logic [AW-1:0]  epc_q, epc_n;
    logic [AW-1:0]  eepc_q;
    logic [EBW-1:0] ebase_q;
    logic           isa_q, ll_q, rv_q;
    logic [AW-1:0]  rpc_q;
    logic [AW-1:0]  ret_tgt;

    assign ret_tgt = use_err ? eepc_q : epc_q;

    always_comb begin
        cause_n = cause_q;
        epc_n   = epc_q;
        if (take_ent) begin
            if (ent_cu)   cause_n[CA_CE_BIT] = 1'b1;
            if (!old_exl) begin
                epc_n = ent_pc | AW'(ent_isa);
                cause_n[CA_BD_BIT] = ent_bd;
            end
            cause_n[CA_EC_HI:CA_EC_LO] = ent_code;
        end else if (wr_ok) begin
            if (wr_sel == SEL_CAUSE)
                cause_n = (cause_q & ~AW'(CAUSE_WMASK)) | (wr_data & AW'(CAUSE_WMASK));
            if (wr_sel == SEL_EPC)
                epc_n = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_rest_q <= AW'(RESET_STAT) & ~LVL_MASK;
            cause_q     <= '0;
            epc_q       <= '0;
            eepc_q      <= '0;
            ebase_q     <= RESET_EBASE[AW-1:EBASE_LSB];
            isa_q       <= 1'b0;
            ll_q        <= 1'b0;
            rv_q        <= 1'b0;
            rpc_q       <= '0;
        end else begin
            cause_q <= cause_n;
            epc_q   <= epc_n;
            rv_q    <= take_ent | take_ret;
            if (take_ent) begin
                isa_q <= 1'b0;
                rpc_q <= vec;
            end else if (take_ret) begin
                isa_q <= ret_tgt[0];
                rpc_q <= {ret_tgt[AW-1:1], 1'b0};
            end
            if (take_ret)    ll_q <= 1'b0;
            else if (ll_set) ll_q <= 1'b1;
            if (wr_ok) begin
                if (wr_sel == SEL_STATUS) stat_rest_q <= wr_data & ~LVL_MASK;
                if (wr_sel == SEL_ERREPC) eepc_q      <= wr_data;
                if (wr_sel == SEL_EBASE)  ebase_q     <= wr_data[AW-1:EBASE_LSB];
            end
        end
    end

    assign status   = stat_rest_q | (AW'(exl) << ST_EXL_BIT) | (AW'(erl) << ST_ERL_BIT);
    assign cause    = cause_q;
    assign epc      = epc_q;
    assign errorepc = eepc_q;
    assign ebase    = {ebase_q, {EBASE_LSB{1'b0}}};
    assign isa      = isa_q;
    assign ll       = ll_q;
    assign rv       = rv_q;
    assign rpc      = rpc_q;

endmodule

// File: rtl/xcpt_ctrl.sv
module xcpt_ctrl
    import xcpt_pkg::*;
#(
    parameter int          AW          = 32,
    parameter int          EBASE_LSB   = 12,
    parameter logic [31:0] RESET_EBASE = 32'h8000_0000,
    parameter logic [31:0] BOOT_BASE   = 32'hBFC0_0200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exc_req,
    input  logic [4:0]    exc_code,
    input  logic          exc_bd,
    input  logic [AW-1:0] exc_pc,
    input  logic          isa_in,
    input  logic          cu_req,
    input  logic          eret_req,
    input  logic          ll_set,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    output logic          redir_valid,
    output logic [AW-1:0] redir_pc,
    output logic          isa_mode,
    output logic          ll_flag,
    output logic [AW-1:0] status_q,
    output logic [AW-1:0] cause_q,
    output logic [AW-1:0] epc_q,
    output logic [AW-1:0] errorepc_q,
    output logic [AW-1:0] ebase_q
);

    localparam logic [31:0] RESET_STAT = 32'h1 << ST_BEV_BIT;

    logic          take_ent, take_ret, wr_ok, wr_stat;
    logic          exl, erl;
    logic [4:0]    eff_code;
    logic [AW-1:0] vec;

    assign take_ent = exc_req | cu_req;
    assign take_ret = eret_req & ~take_ent;
    assign wr_ok    = wr_en & ~take_ent & ~eret_req;
    assign wr_stat  = wr_ok & (wr_sel == SEL_STATUS);
    assign eff_code = cu_req ? EC_CPU : exc_code;

    xcpt_level_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ent    (take_ent),
        .ret    (take_ret),
        .wr     (wr_stat),
        .wr_exl (wr_data[ST_EXL_BIT]),
        .wr_erl (wr_data[ST_ERL_BIT]),
        .exl    (exl),
        .erl    (erl)
    );

    xcpt_vector #(
        .AW        (AW),
        .BOOT_BASE (BOOT_BASE)
    ) u_vec (
        .bev     (status_q[ST_BEV_BIT]),
        .ebase   (ebase_q),
        .old_exl (exl),
        .code    (eff_code),
        .iv      (cause_q[CA_IV_BIT]),
        .vec     (vec)
    );

    xcpt_regfile #(
        .AW          (AW),
        .EBASE_LSB   (EBASE_LSB),
        .RESET_EBASE (RESET_EBASE),
        .RESET_STAT  (RESET_STAT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_ent (take_ent),
        .take_ret (take_ret),
        .wr_ok    (wr_ok),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .ent_code (eff_code),
        .ent_bd   (exc_bd),
        .ent_pc   (exc_pc),
        .ent_isa  (isa_in),
        .ent_cu   (cu_req),
        .old_exl  (exl),
        .use_err  (erl),
        .exl      (exl),
        .erl      (erl),
        .vec      (vec),
        .ll_set   (ll_set),
        .status   (status_q),
        .cause    (cause_q),
        .epc      (epc_q),
        .errorepc (errorepc_q),
        .ebase    (ebase_q),
        .isa      (isa_mode),
        .ll       (ll_flag),
        .rv       (redir_valid),
        .rpc      (redir_pc)
    );

endmodule

// File: rtl/xcpt_ctrl_chk.sv
module xcpt_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        exc_req,
    input logic [4:0]  exc_code,
    input logic        cu_req,
    input logic        eret_req,
    input logic        redir_valid,
    input logic [31:0] redir_pc,
    input logic        isa_mode,
    input logic        ll_flag,
    input logic [31:0] status_q,
    input logic [31:0] cause_q,
    input logic [31:0] epc_q
);

    p_pulse_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && redir_valid) |-> $past(exc_req || cu_req || eret_req));

    p_level_after_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_req || cu_req)) |-> (status_q[1] && !status_q[2]));

    p_frozen_epc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_req || cu_req) && $past(status_q[1])) |-> (epc_q == $past(epc_q)));

    p_code_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_req) && !$past(cu_req)) |-> (cause_q[6:2] == $past(exc_code)));

    p_cu_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cu_req)) |-> (cause_q[6:2] == 5'd11 && cause_q[28]));

    p_isa_cleared_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_req || cu_req)) |-> !isa_mode);

    p_ll_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(eret_req) && !$past(exc_req || cu_req)) |-> !ll_flag);

    p_boot_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exc_req || cu_req) && $past(status_q[22])) |-> (redir_pc[31:12] == 20'hBFC00));

endmodule

bind xcpt_ctrl xcpt_ctrl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_req     (exc_req),
    .exc_code    (exc_code),
    .cu_req      (cu_req),
    .eret_req    (eret_req),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .isa_mode    (isa_mode),
    .ll_flag     (ll_flag),
    .status_q    (status_q),
    .cause_q     (cause_q),
    .epc_q       (epc_q)
);

// File: tb/test_xcpt_ctrl.sv
module test_xcpt_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0, exc_bd = 1'b0, isa_in = 1'b0, cu_req = 1'b0;
    logic        eret_req = 1'b0, ll_set = 1'b0, wr_en = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0, wr_data = '0;
    logic [2:0]  wr_sel = '0;
    logic        redir_valid, isa_mode, ll_flag;
    logic [31:0] redir_pc, status_q, cause_q, epc_q, errorepc_q, ebase_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_status, m_cause, m_epc, m_eepc, m_ebase, m_rpc;
    logic        m_isa, m_ll, m_rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcpt_ctrl i_xcpt_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .exc_bd(exc_bd), .exc_pc(exc_pc), .isa_in(isa_in), .cu_req(cu_req),
        .eret_req(eret_req), .ll_set(ll_set), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .isa_mode(isa_mode), .ll_flag(ll_flag), .status_q(status_q),
        .cause_q(cause_q), .epc_q(epc_q), .errorepc_q(errorepc_q), .ebase_q(ebase_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on every rising edge
    always @(posedge clk) begin
        logic [31:0] tgt, base;
        logic [4:0]  code;
        logic        oldexl;
        if (!rst_n) begin
            m_status = 32'h0040_0000; m_cause = 0; m_epc = 0; m_eepc = 0;
            m_ebase = 32'h8000_0000; m_isa = 0; m_ll = 0; m_rv = 0; m_rpc = 0;
        end else begin
            m_rv = 0;
            if (exc_req || cu_req) begin
                code = cu_req ? 5'd11 : exc_code;
                if (cu_req) m_cause[28] = 1'b1;
                oldexl = m_status[1];
                if (!oldexl) begin
                    m_epc = exc_pc | {31'd0, isa_in};
                    m_cause[31] = exc_bd;
                end
                m_cause[6:2] = code;
                m_status[1] = 1'b1;
                m_status[2] = 1'b0;
                base = m_status[22] ? 32'hBFC0_0380 : m_ebase + 32'h180;
                if (!oldexl) begin
                    if (code == 5'd2 || code == 5'd3) base = base - 32'h180;
                    else if (code == 5'd0 && m_cause[23]) base = base + 32'h80;
                end
                m_rpc = base; m_isa = 0; m_rv = 1;
                if (ll_set) m_ll = 1;
            end else if (eret_req) begin
                if (m_status[2]) begin m_status[2] = 0; tgt = m_eepc; end
                else begin m_status[1] = 0; tgt = m_epc; end
                m_ll = 0; m_isa = tgt[0]; m_rpc = tgt & ~32'h1; m_rv = 1;
            end else begin
                if (ll_set) m_ll = 1;
                if (wr_en) begin
                    case (wr_sel)
                        3'd0: m_status = wr_data;
                        3'd1: m_cause = (m_cause & ~32'h1080_FF00) | (wr_data & 32'h1080_FF00);
                        3'd2: m_epc = wr_data;
                        3'd3: m_eepc = wr_data;
                        3'd4: m_ebase = {wr_data[31:12], 12'h000};
                        default: ;
                    endcase
                end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done && m_status !== 32'bx) begin
            chk("R5 status",      status_q,   m_status);
            chk("R4 cause",       cause_q,    m_cause);
            chk("R2 epc",         epc_q,      m_epc);
            chk("R14 errorepc",   errorepc_q, m_eepc);
            chk("R14 ebase",      ebase_q,    m_ebase);
            chk("R12 isa",        {31'd0, isa_mode},    {31'd0, m_isa});
            chk("R10 ll",         {31'd0, ll_flag},     {31'd0, m_ll});
            chk("R13 redir_valid",{31'd0, redir_valid}, {31'd0, m_rv});
            chk("R6 redir_pc",    redir_pc,   m_rpc);
        end
    end

    task automatic idle();
        exc_req = 0; cu_req = 0; eret_req = 0; ll_set = 0; wr_en = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic raise(input logic [4:0] c, input logic bd, input logic [31:0] pc, input logic isa);
        exc_req = 1; exc_code = c; exc_bd = bd; exc_pc = pc; isa_in = isa;
        step();
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        step();
    endtask

    task automatic ret();
        eret_req = 1;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 status", status_q, 32'h0040_0000);
        chk("R1 cause", cause_q, 32'h0);
        chk("R1 ebase", ebase_q, 32'h8000_0000);
        chk("R1 redir", {31'd0, redir_valid}, 32'h0);
        rst_n = 1;
        step();

        // R2 first entry, R6 boot vector
        raise(5'd8, 1'b0, 32'h0040_1000, 1'b1);
        chk("R2 epc", epc_q, 32'h0040_1001);
        chk("R6 vector", redir_pc, 32'hBFC0_0380);
        chk("R4 cause", cause_q, 32'h0000_0020);
        step();
        chk("R13 pulse ends", {31'd0, redir_valid}, 32'h0);

        // R3 nested entry keeps epc and bd
        raise(5'd9, 1'b1, 32'h0000_0123, 1'b0);
        chk("R3 epc", epc_q, 32'h0040_1001);
        chk("R3 cause", cause_q, 32'h0000_0024);

        // R10 return via epc
        ll_set = 1; step();
        chk("R10 ll set", {31'd0, ll_flag}, 32'h1);
        ret();
        chk("R10 target", redir_pc, 32'h0040_1000);
        chk("R10 isa", {31'd0, isa_mode}, 32'h1);
        chk("R10 ll clear", {31'd0, ll_flag}, 32'h0);
        chk("R10 status", status_q, 32'h0040_0000);

        // R14 writes, R8 vectored interrupt
        wr(3'd0, 32'h0000_FF01);
        wr(3'd4, 32'h8001_0ABC);
        chk("R14 ebase", ebase_q, 32'h8001_0000);
        wr(3'd1, 32'h0080_0300);
        chk("R14 cause", cause_q, 32'h0080_0324);
        wr(3'd6, 32'hFFFF_FFFF);
        raise(5'd0, 1'b1, 32'h0000_2000, 1'b0);
        chk("R8 vector", redir_pc, 32'h8001_0200);
        chk("R4 cause", cause_q, 32'h8080_0300);

        // R7 refill offsets
        ret();
        raise(5'd2, 1'b0, 32'h0000_3000, 1'b0);
        chk("R7 refill", redir_pc, 32'h8001_0000);
        raise(5'd3, 1'b0, 32'h0000_3100, 1'b0);
        chk("R7 nested refill", redir_pc, 32'h8001_0180);

        // R9 error-level return
        wr(3'd0, 32'h0000_0005);
        wr(3'd3, 32'h9000_0003);
        ret();
        chk("R9 target", redir_pc, 32'h9000_0002);
        chk("R9 status", status_q, 32'h0000_0001);
        wr(3'd0, 32'h0000_0007);
        ret();
        chk("R9 both", status_q, 32'h0000_0003);
        ret();
        chk("R10 epc path", redir_pc, 32'h0000_3000);

        // R11 / R12 coprocessor unusable
        wr(3'd2, 32'h0000_4001);
        ret();
        chk("R10 isa from bit0", {31'd0, isa_mode}, 32'h1);
        cu_req = 1; exc_code = 5'd5; exc_pc = 32'h0000_5000; isa_in = 1; exc_bd = 0;
        step();
        chk("R11 cause", cause_q, 32'h1080_032C);
        chk("R12 isa", {31'd0, isa_mode}, 32'h0);
        chk("R11 epc", epc_q, 32'h0000_5001);

        // R13 priority
        exc_req = 1; exc_code = 5'd13; eret_req = 1; wr_en = 1; wr_sel = 3'd0; wr_data = 0;
        step();
        chk("R13 status", status_q, 32'h0000_0003);
        chk("R13 cause", cause_q, 32'h1080_0334);
        chk("R13 epc", epc_q, 32'h0000_5001);

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom % 100;
            exc_req  = (r < 15);
            cu_req   = ($urandom % 25) == 0;
            eret_req = ($urandom % 5) == 0;
            ll_set   = ($urandom % 6) == 0;
            wr_en    = ($urandom % 3) == 0;
            wr_sel   = 3'($urandom % 8);
            wr_data  = $urandom;
            case ($urandom % 6)
                0: exc_code = 5'd0;
                1: exc_code = 5'd2;
                2: exc_code = 5'd3;
                default: exc_code = 5'($urandom);
            endcase
            exc_bd = 1'($urandom);
            isa_in = 1'($urandom);
            exc_pc = $urandom;
            step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule